// File: doc/BRIEF.md
# Synchronous Data-In Request Strobe Generator

This block sits on the target side of a parallel synchronous data-in transfer. It takes bytes from an upstream stream and places each one on the bus data lines. It waits a programmable setup time, then pulses the active-low request line for a programmable assertion time. After the pulse it keeps the request line negated until the transfer period for that byte has run out. The period comes from the negotiated sync factor: the factor times 4 ns gives a time, which is converted to clock cycles and then corrected by a signed trim. Negation takes whatever is left of the period after setup and assertion.

Three speed classes each carry their own setup count, assertion count, trim, minimum sync factor and extra-delay flag. A select input picks the class. All of these settings are captured only when a byte is accepted from idle, so the timing of a transfer stays fixed until the block goes idle again. The initiator answers each request pulse with an acknowledge pulse. A counter tracks how many requests are still waiting for their acknowledge, and no new byte is accepted while that count has reached the configured offset limit.

Back-pressure on the stream works as follows. `s_ready` is high only when the block is idle, or in the last cycle of a negation phase, and the outstanding count is below the limit. A byte transfers on a clock edge where both `s_valid` and `s_ready` are high. The upstream side must hold `s_data` stable while `s_valid` is high and `s_ready` is low.

Top module: `sreq_strobe_gen`

## Requirements
- R1: The accepted byte appears on `bus_data` on the clock after acceptance. It stays unchanged through setup, assertion and negation, until the next byte is accepted.
- R2: Each byte runs three phases in order: setup with `req_n` high, assertion with `req_n` low, then negation with `req_n` high. Setup lasts (stored setup + 1) cycles and assertion lasts (stored assertion + 1) cycles.
- R3: The period in cycles is ceil(effective sync factor × 4000 ps / clock period) plus the class's signed 8-bit trim. The negation phase lasts the period minus the setup and assertion lengths.
- R4: If that negation length comes out below one cycle, it is forced to one cycle.
- R5: A sync factor below the selected class's minimum is replaced by that minimum.
- R6: The 2-bit class select uses index 0, 1 and 2 for the three classes, and values at or above the class count select the last class. When a class's extra-delay bit is set, one cycle is added to its setup phase.
- R7: The first byte after idle gets a setup phase of at least ceil(55 ns / clock period) cycles, which is 6 cycles at 100 MHz. Later bytes in the same burst use the normal setup length.
- R8: `s_ready` is high only in idle or in the last negation cycle, and only while the outstanding count is below `off_limit`. A byte accepted in that last cycle starts its setup phase on the next clock, so back-to-back bytes follow one period apart.
- R9: The outstanding count rises by one when each assertion phase starts and falls by one on each high-to-low edge of `ack_n`. If both happen in the same cycle, the count is unchanged. The count never drops below zero.
- R10: Class settings and the sync factor are captured only when a byte is accepted from idle. Changing them during a burst does not affect that burst.
- R11: After reset, `req_n` is 1, `bus_data` is 0, the outstanding count is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Block can accept a byte |
| s_data | input | DW | Upstream byte |
| cls_sel | input | SEL_W | Speed class select |
| cls_setup | input | NCLASS*CW | Per-class setup count minus one |
| cls_assert | input | NCLASS*CW | Per-class assertion count minus one |
| cls_trim | input | NCLASS*CW | Per-class signed period trim in cycles |
| cls_min_sync | input | NCLASS*CW | Per-class smallest allowed sync factor |
| cls_extra | input | NCLASS | Per-class extra-delay mode bit |
| sync_factor | input | CW | Negotiated sync factor (period / 4 ns) |
| off_limit | input | OW | Maximum outstanding requests |
| ack_n | input | 1 | Bus acknowledge, active low |
| bus_data | output | DW | Bus data lines |
| req_n | output | 1 | Bus request, active low |

## Verification
On every cycle, the embedded assertions check several properties. The request line never goes low straight after rising. Bus data holds still while the request is asserted. An assertion phase starts only after setup. A back-to-back acceptance restarts setup. The offset count never wraps below zero. Period lengths, clamping, class selection, the longer first setup, the freeze on settings and the stall on the offset limit depend on configuration and history, so only the bench's scenarios can show them. The bench does this by comparing every clock against a behavioural model and by measuring the cycle distance between request edges.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  localparam int LEN_W = 12;
  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ASSERT,
    PH_NEGATE
  } phase_e;

  // Phase lengths in clock cycles, each at least one
  typedef struct packed {
    len_t setup;
    len_t first;
    len_t hold;
    len_t negate;
  } lens_t;
endpackage

// File: rtl/sreq_timing.sv
module sreq_timing
  import sreq_pkg::*;
#(
  parameter int NCLASS    = 3,
  parameter int CW        = 8,
  parameter int SEL_W     = 2,
  parameter int CLK_PS    = 10000,
  parameter int DESKEW_PS = 55000
) (
  input  logic [SEL_W-1:0]     cls_sel,
  input  logic [NCLASS*CW-1:0] cls_setup,
  input  logic [NCLASS*CW-1:0] cls_assert,
  input  logic [NCLASS*CW-1:0] cls_trim,
  input  logic [NCLASS*CW-1:0] cls_min_sync,
  input  logic [NCLASS-1:0]    cls_extra,
  input  logic [CW-1:0]        sync_factor,
  output lens_t                lens
);
  localparam int DESK_CYC = (DESKEW_PS + CLK_PS - 1) / CLK_PS;
  localparam int PS_PER_UNIT = 4000;

  int idx, sync_eff, total, s_len, a_len, n_len, f_len;

  always_comb begin
    idx = (int'(cls_sel) >= NCLASS) ? NCLASS - 1 : int'(cls_sel);
    sync_eff = (int'(sync_factor) < int'(cls_min_sync[idx*CW +: CW]))
               ? int'(cls_min_sync[idx*CW +: CW]) : int'(sync_factor);
    total = (sync_eff * PS_PER_UNIT + CLK_PS - 1) / CLK_PS
            + int'($signed(cls_trim[idx*CW +: CW]));
    s_len = int'(cls_setup[idx*CW +: CW]) + 1 + int'(cls_extra[idx]);
    a_len = int'(cls_assert[idx*CW +: CW]) + 1;
    n_len = total - s_len - a_len;
    if (n_len < 1) n_len = 1;
    f_len = (s_len < DESK_CYC) ? DESK_CYC : s_len;
    lens.setup  = len_t'(s_len);
    lens.first  = len_t'(f_len);
    lens.hold   = len_t'(a_len);
    lens.negate = len_t'(n_len);
  end
endmodule

// File: rtl/sreq_offset.sv
module sreq_offset #(
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          ack_n,
  input  logic [OW-1:0] limit,
  output logic          room
);
  logic [OW-1:0] count;
  logic          ack_prev;
  logic          ack_fall;

  assign ack_fall = ack_prev && !ack_n;
  assign room     = count < limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      ack_prev <= 1'b1;
    end else begin
      ack_prev <= ack_n;
      if (inc && !ack_fall)
        count <= count + 1'b1;
      else if (!inc && ack_fall && count != '0)
        count <= count - 1'b1;
    end
  end

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !inc && count == '0) |=> (count == '0));
endmodule

// File: rtl/sreq_fsm.sv
module sreq_fsm
  import sreq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          room,
  input  lens_t         lens,
  output logic [DW-1:0] bus_data,
  output logic          req,
  output logic          req_start
);
  phase_e ph;
  len_t   left;
  lens_t  lat;
  logic   accept;

  assign s_ready   = ((ph == PH_IDLE) || (ph == PH_NEGATE && left == len_t'(1))) && room;
  assign accept    = s_valid && s_ready;
  assign req       = (ph == PH_ASSERT);
  assign req_start = (ph == PH_SETUP) && (left == len_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      left     <= len_t'(1);
      lat      <= '0;
      bus_data <= '0;
    end else if (accept) begin
      bus_data <= s_data;
      ph       <= PH_SETUP;
      if (ph == PH_IDLE) begin
        lat  <= lens;
        left <= lens.first;
      end else begin
        left <= lat.setup;
      end
    end else begin
      case (ph)
        PH_SETUP:
          if (left == len_t'(1)) begin
            ph   <= PH_ASSERT;
            left <= lat.hold;
          end else left <= left - 1'b1;
        PH_ASSERT:
          if (left == len_t'(1)) begin
            ph   <= PH_NEGATE;
            left <= lat.negate;
          end else left <= left - 1'b1;
        PH_NEGATE:
          if (left == len_t'(1)) ph <= PH_IDLE;
          else left <= left - 1'b1;
        default: ;
      endcase
    end
  end

  // R4
  neg_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |=> !req);
  // R2
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(ph) == PH_SETUP));
  // R8
  chain_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ph == PH_NEGATE) |=> (ph == PH_SETUP && !req));
endmodule

// File: rtl/sreq_strobe_gen.sv
module sreq_strobe_gen
  import sreq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NCLASS    = 3,
  parameter int CW        = 8,
  parameter int OW        = 5,
  parameter int SEL_W     = 2,
  parameter int CLK_PS    = 10000,
  parameter int DESKEW_PS = 55000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DW-1:0]        s_data,
  input  logic [SEL_W-1:0]     cls_sel,
  input  logic [NCLASS*CW-1:0] cls_setup,
  input  logic [NCLASS*CW-1:0] cls_assert,
  input  logic [NCLASS*CW-1:0] cls_trim,
  input  logic [NCLASS*CW-1:0] cls_min_sync,
  input  logic [NCLASS-1:0]    cls_extra,
  input  logic [CW-1:0]        sync_factor,
  input  logic [OW-1:0]        off_limit,
  input  logic                 ack_n,
  output logic [DW-1:0]        bus_data,
  output logic                 req_n
);
  lens_t lens;
  logic  room, req, req_start;

  sreq_timing #(.NCLASS(NCLASS), .CW(CW), .SEL_W(SEL_W), .CLK_PS(CLK_PS),
                .DESKEW_PS(DESKEW_PS)) u_timing (
    .cls_sel(cls_sel), .cls_setup(cls_setup), .cls_assert(cls_assert),
    .cls_trim(cls_trim), .cls_min_sync(cls_min_sync), .cls_extra(cls_extra),
    .sync_factor(sync_factor), .lens(lens));

  sreq_offset #(.OW(OW)) u_offset (
    .clk(clk), .rst_n(rst_n), .inc(req_start), .ack_n(ack_n),
    .limit(off_limit), .room(room));

  sreq_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .room(room), .lens(lens), .bus_data(bus_data),
    .req(req), .req_start(req_start));

  assign req_n = ~req;

  // R1
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $stable(bus_data));
  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && $past(!req_n)) |-> $stable(bus_data));
endmodule

// File: tb/sim_sreq_strobe_gen.sv
module sim_sreq_strobe_gen;
  localparam int DW = 8, NC = 3, CW = 8, OW = 5, CLK_PS = 10000, DESK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DW-1:0] s_data = '0;
  logic [1:0] cls_sel = 2'd0;
  logic [NC*CW-1:0] cls_setup, cls_assert, cls_trim, cls_min_sync;
  logic [NC-1:0] cls_extra;
  logic [CW-1:0] sync_factor = 8'd50;
  logic [OW-1:0] off_limit = 5'd15;
  logic ack_n = 1'b1;
  logic [DW-1:0] bus_data;
  logic req_n;

  int c_setup[NC]  = '{2, 2, 1};
  int c_assert[NC] = '{5, 3, 1};
  int c_trim[NC]   = '{0, 0, -1};
  int c_min[NC]    = '{50, 25, 12};
  int c_extra[NC]  = '{0, 0, 1};

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      cls_setup[i*CW +: CW]    = CW'(c_setup[i]);
      cls_assert[i*CW +: CW]   = CW'(c_assert[i]);
      cls_trim[i*CW +: CW]     = CW'(c_trim[i]);
      cls_min_sync[i*CW +: CW] = CW'(c_min[i]);
      cls_extra[i]             = c_extra[i][0];
    end
  end

  sreq_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cls_sel(cls_sel), .cls_setup(cls_setup),
    .cls_assert(cls_assert), .cls_trim(cls_trim), .cls_min_sync(cls_min_sync),
    .cls_extra(cls_extra), .sync_factor(sync_factor), .off_limit(off_limit),
    .ack_n(ack_n), .bus_data(bus_data), .req_n(req_n));

  int n_tests = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int m_ph = 0, m_left = 1, m_out = 0, m_data = 0;
  int l_s = 1, l_f = 1, l_a = 1, l_n = 1, first_acc = 0;
  bit m_ackp = 1'b1, m_acc = 1'b0;

  task automatic calc(output int s, output int f, output int a, output int n);
    int idx, se, total;
    idx = (int'(cls_sel) >= NC) ? NC - 1 : int'(cls_sel);
    se = (int'(sync_factor) < c_min[idx]) ? c_min[idx] : int'(sync_factor);
    total = (se * 4000 + CLK_PS - 1) / CLK_PS + c_trim[idx];
    s = c_setup[idx] + 1 + c_extra[idx];
    a = c_assert[idx] + 1;
    n = total - s - a;
    if (n < 1) n = 1;
    f = (s < DESK) ? DESK : s;
  endtask

  function automatic bit m_ready();
    return ((m_ph == 0) || (m_ph == 3 && m_left == 1)) && (m_out < int'(off_limit));
  endfunction

  always @(posedge clk) begin
    bit acc, inc, ackf;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_left = 1; m_out = 0; m_data = 0; m_ackp = 1'b1; m_acc = 1'b0;
    end else begin
      acc  = s_valid && m_ready();
      inc  = (m_ph == 1 && m_left == 1);
      ackf = m_ackp && !ack_n;
      m_ackp = ack_n;
      if (inc && !ackf) m_out++;
      else if (!inc && ackf && m_out > 0) m_out--;
      if (acc) begin
        m_data = int'(s_data);
        if (m_ph == 0) begin
          calc(l_s, l_f, l_a, l_n);
          m_left = l_f;
          first_acc = cyc;
        end else m_left = l_s;
        m_ph = 1;
      end else begin
        case (m_ph)
          1: if (m_left == 1) begin m_ph = 2; m_left = l_a; end else m_left--;
          2: if (m_left == 1) begin m_ph = 3; m_left = l_n; end else m_left--;
          3: if (m_left == 1) m_ph = 0; else m_left--;
          default: ;
        endcase
      end
      m_acc = acc;
    end
  end

  // Stream driver
  int sent = 0, target = 0;
  int sentq[$];
  always @(posedge clk) begin
    #1;
    if (m_acc && s_valid) begin
      sentq.push_back(int'(s_data));
      sent++;
      if (sent >= target) s_valid = 1'b0;
      else s_data = DW'(sent * 37 + 8'h5A);
    end
  end

  // Acknowledge responder
  bit ack_auto = 1'b1, ack_man = 1'b1;
  logic [2:0] ack_sh = 3'b111;
  always @(posedge clk) begin
    #1;
    ack_sh = {ack_sh[1:0], req_n};
    ack_n = ack_auto ? ack_sh[1] : ack_man;
  end

  // Per-clock comparison and edge logging
  int falls[$];
  int rises[$];
  int fall_idx = 0;
  logic prev_req_n = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_n === (m_ph != 2), "R2 req_n vs model", int'(req_n), int'(m_ph != 2));
      chk(s_ready === m_ready(), "R8 s_ready vs model", int'(s_ready), int'(m_ready()));
      chk(int'(bus_data) == m_data, "R1 bus_data vs model", int'(bus_data), m_data);
      if (prev_req_n && !req_n) begin
        falls.push_back(cyc);
        if (fall_idx < sentq.size())
          chk(int'(bus_data) == sentq[fall_idx], "R1 byte at REQ", int'(bus_data), sentq[fall_idx]);
        fall_idx++;
      end
      if (!prev_req_n && req_n) rises.push_back(cyc);
    end
    prev_req_n = req_n;
  end

  task automatic start_burst(input int n);
    @(posedge clk); #2;
    falls.delete(); rises.delete(); sentq.delete();
    fall_idx = 0; sent = 0; target = n;
    s_data = DW'(8'h5A);
    s_valid = 1'b1;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (!(sent >= target && m_ph == 0));
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic check_burst(input int n, input int period, input int width,
                             input int first_setup, input string tag);
    chk(falls.size() == n, {tag, " REQ count"}, falls.size(), n);
    if (falls.size() > 0)
      chk(falls[0] - first_acc == first_setup, {tag, " first setup"}, falls[0] - first_acc, first_setup);
    for (int i = 1; i < falls.size(); i++)
      chk(falls[i] - falls[i-1] == period, {tag, " period"}, falls[i] - falls[i-1], period);
    for (int i = 0; i < rises.size() && i < falls.size(); i++)
      chk(rises[i] - falls[i] == width, {tag, " assert width"}, rises[i] - falls[i], width);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; s_valid = 1'b0; target = sent;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(req_n === 1'b1, "R11 req_n in reset", int'(req_n), 1);
    chk(bus_data === '0, "R11 bus_data in reset", int'(bus_data), 0);
    repeat (2) @(posedge clk);
    #2; rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready === 1'b1, "R11 ready after reset", int'(s_ready), 1);

    // R3 R7: slow class, sync 50 -> 20 cycles, first setup raised to 6
    cls_sel = 2'd0; sync_factor = 8'd50;
    start_burst(3); wait_idle();
    check_burst(3, 20, 6, DESK, "R3 R7");

    // R5: request 12 on class 1, clamped to 25 -> 10 cycles
    cls_sel = 2'd1; sync_factor = 8'd12;
    start_burst(4); wait_idle();
    check_burst(4, 10, 4, DESK, "R5");

    // R4 R6: class 2 with extra delay and trim -1, negation forced to 1
    cls_sel = 2'd2; sync_factor = 8'd12;
    start_burst(4); wait_idle();
    check_burst(4, 6, 2, DESK, "R4 R6");

    // R6: select value 3 maps to last class
    cls_sel = 2'd3;
    start_burst(3); wait_idle();
    check_burst(3, 6, 2, DESK, "R6 sel3");

    // R3 R7: long setup beats deskew, positive trim
    cls_sel = 2'd1; c_setup[1] = 9; c_trim[1] = 3; sync_factor = 8'd40;
    start_burst(3); wait_idle();
    check_burst(3, 19, 4, 10, "R3 R7 trim");
    c_setup[1] = 2; c_trim[1] = 0;

    // R10: settings changed mid-burst are ignored
    cls_sel = 2'd0; sync_factor = 8'd50;
    start_burst(3);
    repeat (3) @(posedge clk);
    #2; c_setup[0] = 7; c_assert[0] = 1; sync_factor = 8'd100;
    wait_idle();
    check_burst(3, 20, 6, DESK, "R10");
    c_setup[0] = 2; c_assert[0] = 5; sync_factor = 8'd50;

    // R9: offset limit stalls the stream until ACK
    do_reset();
    ack_auto = 1'b0; ack_man = 1'b1; off_limit = 5'd2;
    cls_sel = 2'd1; sync_factor = 8'd25;
    start_burst(4);
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(falls.size() == 2, "R9 stalled at limit", falls.size(), 2);
    chk(s_ready === 1'b0, "R9 ready low at limit", int'(s_ready), 0);
    @(posedge clk); #2; ack_man = 1'b0;
    @(posedge clk); #2; ack_man = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(falls.size() == 3, "R9 one more after ACK", falls.size(), 3);
    do_reset();
    ack_auto = 1'b1; off_limit = 5'd15;
    repeat (5) @(posedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule